// File: doc/BRIEF.md
# Bit-Serial Speculative Cut-Through Mesh Router Node

This block is one router node of a two-dimensional mesh whose links carry one bit per clock. A packet is a contiguous run of valid bits. It opens with two address flits of `CW` bits each, both sent most-significant bit first. The first flit is the column coordinate (dimension 0) and the second is the row coordinate (dimension 1). The payload follows, and the packet ends when valid drops. Routing is in dimension order, so a packet travels along its column axis, turns at most once, and then travels along its row axis.

The node does not wait for an address before forwarding. Every bit that arrives on a dimension input is copied, one cycle later, onto the output of the same dimension. The address bits are compared against the node's coordinate as they pass. A mismatch on any address bit means the speculation was right, and the packet streams through untouched. If the whole address flit matches, the speculation was wrong. The node then ends the outgoing stream with a dead flit of `CW` ones, which no node ever accepts as an address. It strips the matched flit and steers the remaining bits to the next stage.

After a column match, the remaining bits enter the row lane. That lane treats them exactly like traffic arriving on the row input, so they too are forwarded speculatively on the row output. After a row match, the payload leaves on the local delivery port.

The node makes the following assumptions about its traffic:
- Row-input traffic and turned traffic never overlap.
- After a packet that matched, each lane sees at least `CW+1` idle cycles before its next packet.
- No coordinate equals the all-ones value.

Top module: `mp_node`

## Requirements
- R1: Each valid bit on a dimension input appears on the output of the same dimension exactly one cycle later while the address flit is streaming, whether or not that flit later matches.
- R2: If any address bit, compared MSB first, differs from the node coordinate, the whole packet (address, second flit, payload) leaves on the same-dimension output unchanged and one cycle later, and nothing goes to the other outputs.
- R3: When all `CW` bits of a lane's address flit match, that lane's output carries the address bits, then exactly `CW` one-bits (the dead flit), then valid low.
- R4: After a column match, the bits following the column flit appear on the row output two cycles after they entered the column input, and are themselves forwarded speculatively there.
- R5: After a row match (row input or turned traffic), the bits following the row flit leave on the local port, valid and in order, one cycle after entering the row lane.
- R6: An all-ones address flit never matches, so the packet is forwarded straight.
- R7: A drop of input valid returns a lane to address decoding, so a packet after a one-cycle gap (straight traffic) or a `CW+1`-cycle gap (after a match) is decoded afresh.
- R8: Synchronous active-low reset clears all outputs in the cycle after it is sampled low, and drops any partial packet.
- R9: A packet with no payload that matches both coordinates still produces both dead flits and nothing on the local port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| x_in_valid | input | 1 | Column-axis input link, bit valid |
| x_in_bit | input | 1 | Column-axis input link, data bit |
| y_in_valid | input | 1 | Row-axis input link, bit valid |
| y_in_bit | input | 1 | Row-axis input link, data bit |
| x_out_valid | output | 1 | Column-axis output link, bit valid |
| x_out_bit | output | 1 | Column-axis output link, data bit |
| y_out_valid | output | 1 | Row-axis output link, bit valid |
| y_out_bit | output | 1 | Row-axis output link, data bit |
| local_valid | output | 1 | Local delivery, bit valid |
| local_bit | output | 1 | Local delivery, data bit |

## Verification
A wrong address-bit index or comparison shows at the ports within one flit time, as a missing dead flit or an unexpected stream on the row or local outputs. A lane state that is not cleared at the end of a packet corrupts the very next packet: its bits vanish from the straight output because they are diverted to a branch. A dead-flit counter of the wrong length shows as extra or missing ones just before valid falls. Comparing every output on every cycle against an independent model catches each of these on the first wrong cycle.

// File: rtl/mp_pkg.sv
// Shared types for the bit-serial speculative router node.
package mp_pkg;
    // Phase of one dimension lane within the current packet.
    typedef enum logic [1:0] {
        LANE_ADDR     = 2'd0,  // address flit streaming, being compared
        LANE_STRAIGHT = 2'd1,  // mismatch seen: forward the rest straight
        LANE_BRANCH   = 2'd2   // full match: steer the rest to the branch
    } lane_phase_e;
endpackage

// File: rtl/mp_hdr_match.sv
// Incremental MSB-first address comparator.
// Assumes: bits arrive one per cycle while bit_vld is high, and a packet
// ends when bit_vld drops. hdr_phase is high while the lane decodes.
// full_match pulses on the last address bit when every bit matched;
// miss pulses on the first address bit that differs.
module mp_hdr_match #(
    parameter int unsigned CW    = 4,
    parameter int unsigned COORD = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic bit_dat,
    input  logic hdr_phase,
    output logic full_match,
    output logic miss
);
    localparam int unsigned IDXW = (CW > 1) ? $clog2(CW) : 1;
    localparam logic [CW-1:0] COORD_L = CW'(COORD);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(CW - 1);

    logic [IDXW-1:0] idx;
    logic [IDXW-1:0] sel;
    logic            bit_eq;
    logic            at_last;

    // Select the coordinate bit for the current address position (MSB first).
    always_comb begin
        sel     = LAST_IDX - idx;
        bit_eq  = (bit_dat == COORD_L[sel]);
        at_last = (idx == LAST_IDX);
    end

    // Flag the decoding outcome for the bit on the input this cycle.
    always_comb begin
        full_match = bit_vld && hdr_phase && bit_eq && at_last;
        miss       = bit_vld && hdr_phase && !bit_eq;
    end

    // Count address bits; clear at packet end or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !bit_vld) begin
            idx <= '0;
        end else if (hdr_phase && !at_last) begin
            idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/mp_dead_gen.sv
// Dead-flit generator: once loaded, stays active for exactly CW cycles so
// the lane can append CW one-bits to a cancelled speculative stream.
// Assumes no reload while active (lane gap rule).
module mp_dead_gen #(
    parameter int unsigned CW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic active
);
    localparam int unsigned CNTW = $clog2(CW + 1);
    localparam logic [CNTW-1:0] LEN = CNTW'(CW);

    logic [CNTW-1:0] remain;

    // Load the dead-flit length on a match, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= LEN;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    // Active while bits of the dead flit remain to be sent.
    always_comb active = (remain != '0);
endmodule

// File: rtl/mp_lane.sv
// One dimension lane. Every input bit is forwarded speculatively to the
// straight output with one register stage. The address flit is compared
// on the fly. On a full match the straight stream is closed with a dead
// flit and the remaining bits go to the branch output, one cycle later.
// Assumes at least CW+1 idle cycles after a matched packet.
module mp_lane
    import mp_pkg::*;
#(
    parameter int unsigned CW    = 4,
    parameter int unsigned COORD = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_vld,
    input  logic in_bit,
    output logic str_vld,
    output logic str_bit,
    output logic br_vld,
    output logic br_bit
);
    lane_phase_e phase, phase_nx;
    logic        full_match;
    logic        miss;
    logic        dead_on;
    logic        fwd_now;
    logic        br_now;

    mp_hdr_match #(.CW(CW), .COORD(COORD)) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_vld    (in_vld),
        .bit_dat    (in_bit),
        .hdr_phase  (phase == LANE_ADDR),
        .full_match (full_match),
        .miss       (miss)
    );

    mp_dead_gen #(.CW(CW)) u_dead (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (full_match),
        .active (dead_on)
    );

    // Next phase: packet end resets to decoding; decode outcome picks a path.
    always_comb begin
        phase_nx = phase;
        if (!in_vld) begin
            phase_nx = LANE_ADDR;
        end else if (phase == LANE_ADDR) begin
            if (miss) begin
                phase_nx = LANE_STRAIGHT;
            end else if (full_match) begin
                phase_nx = LANE_BRANCH;
            end
        end
    end

    // Hold the lane phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= LANE_ADDR;
        end else begin
            phase <= phase_nx;
        end
    end

    // Decide where the current input bit goes.
    always_comb begin
        fwd_now = in_vld && (phase != LANE_BRANCH);
        br_now  = in_vld && (phase == LANE_BRANCH);
    end

    // Register the straight output: forwarded bit or dead-flit one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            str_vld <= 1'b0;
            str_bit <= 1'b0;
        end else begin
            str_vld <= fwd_now || dead_on;
            str_bit <= dead_on || (fwd_now && in_bit);
        end
    end

    // Register the branch output: bits after the matched flit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            br_vld <= 1'b0;
            br_bit <= 1'b0;
        end else begin
            br_vld <= br_now;
            br_bit <= br_now && in_bit;
        end
    end
endmodule

// File: rtl/mp_node.sv
// Bit-serial speculative cut-through router node for a 2-D mesh.
// Lane 0 decodes the column flit of traffic on the column axis; its
// branch (turned traffic) merges with the row input into lane 1, which
// decodes the row flit and delivers matched payload to the local port.
// Assumes: row input and turned traffic never overlap (row input wins if
// they do); NODE_X and NODE_Y are below 2**CW-1.
module mp_node #(
    parameter int unsigned CW     = 4,
    parameter int unsigned NODE_X = 3,
    parameter int unsigned NODE_Y = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic x_in_valid,
    input  logic x_in_bit,
    input  logic y_in_valid,
    input  logic y_in_bit,
    output logic x_out_valid,
    output logic x_out_bit,
    output logic y_out_valid,
    output logic y_out_bit,
    output logic local_valid,
    output logic local_bit
);
    localparam int unsigned NDIM = 2;

    logic [NDIM-1:0] ln_in_v, ln_in_b;
    logic [NDIM-1:0] ln_str_v, ln_str_b;
    logic [NDIM-1:0] ln_br_v, ln_br_b;

    // Feed lanes: column input to lane 0; row input or turned bits to lane 1.
    always_comb begin
        ln_in_v[0] = x_in_valid;
        ln_in_b[0] = x_in_valid && x_in_bit;
        ln_in_v[1] = y_in_valid || ln_br_v[0];
        ln_in_b[1] = y_in_valid ? y_in_bit : ln_br_b[0];
    end

    for (genvar d = 0; d < NDIM; d++) begin : g_lane
        mp_lane #(
            .CW    (CW),
            .COORD ((d == 0) ? NODE_X : NODE_Y)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_vld  (ln_in_v[d]),
            .in_bit  (ln_in_b[d]),
            .str_vld (ln_str_v[d]),
            .str_bit (ln_str_b[d]),
            .br_vld  (ln_br_v[d]),
            .br_bit  (ln_br_b[d])
        );
    end

    // Drive the node outputs from the lanes.
    always_comb begin
        x_out_valid = ln_str_v[0];
        x_out_bit   = ln_str_b[0];
        y_out_valid = ln_str_v[1];
        y_out_bit   = ln_str_b[1];
        local_valid = ln_br_v[1];
        local_bit   = ln_br_b[1];
    end
endmodule

// File: rtl/mp_node_chk.sv
// Port-level checker for mp_node, attached by bind.
module mp_node_chk (
    input logic clk,
    input logic rst_n,
    input logic x_in_valid,
    input logic x_in_bit,
    input logic y_in_valid,
    input logic y_in_bit,
    input logic x_out_valid,
    input logic x_out_bit,
    input logic y_out_valid,
    input logic y_out_bit,
    input logic local_valid,
    input logic local_bit
);
    // R1: a zero on the column output can only be a copied input zero.
    assert_x_zero_is_copy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (x_out_valid && !x_out_bit) |-> ($past(x_in_valid) && !$past(x_in_bit)));

    // R3: column output is valid only from input or as a dead-flit continuation.
    assert_x_valid_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        x_out_valid |-> ($past(x_in_valid) || $past(x_out_valid)));

    // R4: a zero on the row output comes from the row input or turned column input.
    assert_y_zero_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (y_out_valid && !y_out_bit) |-> ($past(y_in_valid) || $past(x_in_valid, 2)));

    // R5: local delivery needs row-lane input one cycle earlier.
    assert_local_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        local_valid |-> ($past(y_in_valid) || $past(x_in_valid, 2)));

    // R8: reset sampled low clears every output at the next edge.
    assert_reset_clears_R8: assert property (@(posedge clk)
        !rst_n |=> (!x_out_valid && !y_out_valid && !local_valid));
endmodule

bind mp_node mp_node_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .x_in_valid  (x_in_valid),
    .x_in_bit    (x_in_bit),
    .y_in_valid  (y_in_valid),
    .y_in_bit    (y_in_bit),
    .x_out_valid (x_out_valid),
    .x_out_bit   (x_out_bit),
    .y_out_valid (y_out_valid),
    .y_out_bit   (y_out_bit),
    .local_valid (local_valid),
    .local_bit   (local_bit)
);

// File: tb/mp_node_test.sv
module mp_node_test;
    localparam int CW   = 4;
    localparam int MY_X = 6;
    localparam int MY_Y = 9;
    localparam int NCYC = 540;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic x_in_valid = 1'b0, x_in_bit = 1'b0;
    logic y_in_valid = 1'b0, y_in_bit = 1'b0;
    logic x_out_valid, x_out_bit, y_out_valid, y_out_bit, local_valid, local_bit;

    mp_node #(.CW(CW), .NODE_X(MY_X), .NODE_Y(MY_Y)) uut (
        .clk(clk), .rst_n(rst_n),
        .x_in_valid(x_in_valid), .x_in_bit(x_in_bit),
        .y_in_valid(y_in_valid), .y_in_bit(y_in_bit),
        .x_out_valid(x_out_valid), .x_out_bit(x_out_bit),
        .y_out_valid(y_out_valid), .y_out_bit(y_out_bit),
        .local_valid(local_valid), .local_bit(local_bit)
    );

    // Stimulus schedule and expected per-cycle outputs (0 column, 1 row, 2 local).
    bit    in_v [2][NCYC];
    bit    in_b [2][NCYC];
    bit    rst_s [NCYC];
    bit    exp_v [3][NCYC];
    bit    exp_b [3][NCYC];
    string exp_tag [3][NCYC];
    int    tests = 0;
    int    fails = 0;
    bit    done = 1'b0;

    function automatic bit pbit(logic [63:0] p, int n, int i);
        return p[n-1-i];
    endfunction

    function automatic int head(logic [63:0] p, int n);
        return int'((p >> (n - CW)) & ((64'd1 << CW) - 1));
    endfunction

    task automatic put(int ch, int c, bit b, string t);
        if (c < NCYC) begin
            exp_v[ch][c]   = 1'b1;
            exp_b[ch][c]   = b;
            exp_tag[ch][c] = t;
        end
    endtask

    task automatic drive(int lane, int s, logic [63:0] p, int n);
        for (int i = 0; i < n; i++) begin
            in_v[lane][s+i] = 1'b1;
            in_b[lane][s+i] = pbit(p, n, i);
        end
    endtask

    // Row lane model: bit i entering at cycle s+i.
    task automatic model_y(int s, logic [63:0] p, int n, string ts, string td, string tb);
        if (head(p, n) != MY_Y) begin
            for (int i = 0; i < n; i++) put(1, s + 1 + i, pbit(p, n, i), ts);
        end else begin
            for (int i = 0; i < CW; i++) put(1, s + 1 + i, pbit(p, n, i), ts);
            for (int k = 0; k < CW; k++) put(1, s + 1 + CW + k, 1'b1, td);
            for (int k = 0; k < n - CW; k++) put(2, s + 1 + CW + k, pbit(p, n, CW + k), tb);
        end
    endtask

    // Column lane model; matched traffic re-enters the row lane.
    task automatic model_x(int s, logic [63:0] p, int n, string ts);
        int rest;
        rest = n - CW;
        if (head(p, n) != MY_X) begin
            for (int i = 0; i < n; i++) put(0, s + 1 + i, pbit(p, n, i), ts);
        end else begin
            for (int i = 0; i < CW; i++) put(0, s + 1 + i, pbit(p, n, i), ts);
            for (int k = 0; k < CW; k++) put(0, s + 1 + CW + k, 1'b1, "R3");
            if (rest >= CW)
                model_y(s + CW + 1, p & ((64'd1 << rest) - 1), rest, "R4",
                        (rest == CW) ? "R9" : "R5", "R5");
        end
    endtask

    task automatic send_x(int s, logic [63:0] p, int n, string ts);
        drive(0, s, p, n);
        model_x(s, p, n, ts);
    endtask

    task automatic send_y(int s, logic [63:0] p, int n, string ts);
        drive(1, s, p, n);
        model_y(s, p, n, ts, "R5", "R5");
    endtask

    task automatic check(int ch, logic v, logic b, int c);
        tests++;
        if ({v, b} !== {exp_v[ch][c], exp_b[ch][c]}) begin
            fails++;
            $display("FAIL %s cycle %0d port %0d: actual v=%b b=%b expected v=%b b=%b",
                     exp_tag[ch][c], c, ch, v, b, exp_v[ch][c], exp_b[ch][c]);
        end
    endtask

    initial begin
        for (int c = 0; c < NCYC; c++) begin
            rst_s[c] = (c >= 5);
            for (int ch = 0; ch < 3; ch++) exp_tag[ch][c] = (c < 6) ? "R8" : "R3";
        end
        // R2: column mismatch on second bit, and on last bit.
        send_x(10, {4'd2, 4'd5, 6'b101101}, 14, "R2");
        send_x(40, {4'd7, 4'd1, 5'b11010}, 13, "R2");
        // R1/R3/R4: column match, row mismatch -> turn and pass north.
        send_x(70, {4'd6, 4'd3, 7'b1001011}, 15, "R1");
        // R1/R3/R4/R5: both match -> local delivery.
        send_x(110, {4'd6, 4'd9, 9'b110010111}, 17, "R1");
        // R5: row input match; R2: row mismatch on last bit.
        send_y(150, {4'd9, 6'b011101}, 10, "R1");
        send_y(180, {4'd8, 5'b10011}, 9, "R2");
        // R6: all-ones addresses never match.
        send_y(210, {4'd15, 4'b0110}, 8, "R6");
        send_x(240, {4'd15, 4'd9, 4'b1010}, 12, "R6");
        // R9: header-only packet addressed to this node.
        send_x(270, {4'd6, 4'd9}, 8, "R1");
        // R7: back-to-back packets with minimal gaps.
        send_x(300, {4'd1, 4'd2, 4'b0101}, 12, "R7");
        send_x(313, {4'd3, 4'd9, 2'b10}, 10, "R7");
        send_x(330, {4'd6, 4'd3, 4'b1100}, 12, "R1");
        send_x(347, {4'd4, 4'd6, 3'b011}, 11, "R7");
        // R8: reset in the middle of a turning packet.
        send_x(400, {4'd6, 4'd9, 8'b10110011}, 16, "R1");
        for (int c = 406; c < 420; c++) begin
            in_v[0][c] = 1'b0;
            in_b[0][c] = 1'b0;
        end
        for (int c = 406; c < 409; c++) rst_s[c] = 1'b0;
        for (int c = 407; c < 466; c++)
            for (int ch = 0; ch < 3; ch++) begin
                exp_v[ch][c] = 1'b0; exp_b[ch][c] = 1'b0; exp_tag[ch][c] = "R8";
            end
        send_x(470, {4'd6, 4'd9, 3'b101}, 11, "R8");

        for (int c = 0; c < NCYC; c++) begin
            @(negedge clk);
            check(0, x_out_valid, x_out_bit, c);
            check(1, y_out_valid, y_out_bit, c);
            check(2, local_valid, local_bit, c);
            rst_n      = rst_s[c];
            x_in_valid = in_v[0][c];
            x_in_bit   = in_b[0][c];
            y_in_valid = in_v[1][c];
            y_in_bit   = in_b[1][c];
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R7 watchdog: actual run still active, expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule